// File: doc/BRIEF.md
# Serial Memory Sequential Read Engine

This block is the read datapath of an SPI mode-0 slave for a 4096-byte memory. An external command decoder watches the opcode byte; when it recognises the read opcode (0x03) it pulses `start_i`. The engine then shifts in a 16-bit address on rising SCK. From the fall of SCK that follows the last address bit it streams bytes out on `so_o`, MSB first. It fetches each byte from a synchronous memory port and advances the address after each byte. When it passes the top of the array it wraps to location 0, so one command can stream the array without end. Raising chip select ends the transfer at any bit.

SCK, chip select and the serial input are sampled in the `clk_i` domain. Each SCK half period must last at least four `clk_i` cycles. That margin lets a memory fetch complete between a request and the falling edge that needs the data.

Top module: `spi_seq_read`

## Requirements
- R1: While and after reset, with no command active, `so_oe_o`, `so_o` and `mem_req_o` are low.
- R2: A `start_i` pulse while `cs_ni` is low begins the address phase. The next 16 rising SCK edges sample `si_i` as the address, most significant bit first.
- R3: Address bits 15..12 have no effect. The first `mem_addr_o` of a command equals address bits 11..0.
- R4: The addressed byte appears on `so_o` MSB first. Each bit is updated after a falling SCK edge, and the first bit follows the fall after the 16th address rise.
- R5: After each byte, the byte at the next address follows on the next falling edge, with no idle bit between bytes.
- R6: After the byte at 0xFFF, the byte at 0x000 follows and streaming continues.
- R7: Raising `cs_ni` ends the command at any bit position, in the address or the data phase. `so_oe_o` drops and the engine returns to idle, so the next command behaves normally.
- R8: `so_oe_o` is high only from the first data-phase falling edge until `cs_ni` rises. `so_o` is low whenever `so_oe_o` is low.
- R9: `mem_req_o` is a one-cycle pulse with `mem_addr_o`, and read data is expected on `mem_rdata_i` one cycle later. One request is issued at the end of the address, and one on the fall that presents the last bit of each byte. N complete bytes therefore cost N+1 requests.
- R10: A `start_i` pulse while `cs_ni` is high is ignored. SCK activity after `cs_ni` falls then produces no data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, samples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock (mode 0) |
| si_i | input | 1 | Serial data in |
| start_i | input | 1 | Read opcode seen, one-cycle pulse from decoder |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for `so_o` |
| mem_req_o | output | 1 | Memory read request pulse |
| mem_addr_o | output | 12 | Memory read address |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after request |

## Verification
The assertions check these properties on every cycle. The address register must wrap to zero after the top location. Chip select high must force the engine idle. The output enable may be high only in the data phase. Every memory request must be a single-cycle pulse. The prefetched byte must be valid whenever a byte boundary loads the shifter. Only the bench's scenarios show the data itself: the bit order, the values streamed across the 0xFFF wrap, the ignored upper address bits, aborts in both phases and the request count per command. The bench compares these against a behavioural model of the memory and the serial master.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int unsigned CMD_ADDR_BITS = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } rd_state_e;
endpackage

// File: rtl/spi_sck_edge.sv
module spi_sck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;
endmodule

// File: rtl/spi_rd_addr.sv
module spi_rd_addr #(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  // shifting 16 bits through AW bits drops the upper don't-care bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (shift_i) addr_q <= {addr_q[AW-2:0], bit_i};
    else if (inc_i)   addr_q <= addr_q + AW'(1);
  end

  assign addr_o = addr_q;

  // R6
  addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !shift_i && addr_q == {AW{1'b1}}) |=> (addr_q == '0));
endmodule

// File: rtl/spi_rd_txsh.sv
module spi_rd_txsh #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [DW-1:0] data_i,
  output logic          msb_o
);
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[DW-2:0], 1'b0};
  end

  assign msb_o = sh_q[DW-1];
endmodule

// File: rtl/spi_seq_read.sv
module spi_seq_read
  import spi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              start_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned ABIT_W = $clog2(CMD_ADDR_BITS);
  localparam int unsigned DBIT_W = $clog2(DATA_W);
  localparam logic [ABIT_W-1:0] ABIT_LAST = ABIT_W'(CMD_ADDR_BITS - 1);
  localparam logic [DBIT_W-1:0] DBIT_LAST = DBIT_W'(DATA_W - 1);

  rd_state_e         state_q;
  logic [ABIT_W-1:0] abit_q;
  logic [DBIT_W-1:0] dbit_q;
  logic              active_q, req_q, rvalid_q, pref_vld_q;
  logic [DATA_W-1:0] pref_q;
  logic              sck_rise, sck_fall;
  logic              addr_shift, byte_load, bit_shift;
  logic              tx_msb;

  spi_sck_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  assign addr_shift = !cs_ni && state_q == ST_ADDR && sck_rise;
  assign byte_load  = !cs_ni && state_q == ST_DATA && sck_fall && dbit_q == '0;
  assign bit_shift  = !cs_ni && state_q == ST_DATA && sck_fall && dbit_q != '0;

  spi_rd_addr #(.AW(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (addr_shift),
    .bit_i   (si_i),
    .inc_i   (byte_load),
    .addr_o  (mem_addr_o)
  );

  spi_rd_txsh #(.DW(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (byte_load),
    .shift_i (bit_shift),
    .data_i  (pref_q),
    .msb_o   (tx_msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      abit_q   <= '0;
      dbit_q   <= '0;
      active_q <= 1'b0;
      req_q    <= 1'b0;
    end else if (cs_ni) begin
      state_q  <= ST_IDLE;
      abit_q   <= '0;
      dbit_q   <= '0;
      active_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ADDR;
          abit_q  <= '0;
        end
        ST_ADDR: if (sck_rise) begin
          abit_q <= abit_q + ABIT_W'(1);
          if (abit_q == ABIT_LAST) begin
            state_q <= ST_DATA;
            dbit_q  <= '0;
            req_q   <= 1'b1;
          end
        end
        ST_DATA: if (sck_fall) begin
          dbit_q <= dbit_q + DBIT_W'(1);
          if (dbit_q == '0) active_q <= 1'b1;
          // prefetch next byte while its predecessor's last bit is on the wire
          if (dbit_q == DBIT_LAST) req_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q   <= 1'b0;
      pref_vld_q <= 1'b0;
      pref_q     <= '0;
    end else if (cs_ni) begin
      rvalid_q   <= 1'b0;
      pref_vld_q <= 1'b0;
    end else begin
      rvalid_q <= req_q;
      if (rvalid_q) begin
        pref_q     <= mem_rdata_i;
        pref_vld_q <= 1'b1;
      end else if (byte_load) begin
        pref_vld_q <= 1'b0;
      end
    end
  end

  assign mem_req_o = req_q;
  assign so_oe_o   = active_q & ~cs_ni;
  assign so_o      = so_oe_o & tx_msb;

  // R7
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (state_q == ST_IDLE));

  // R5
  pref_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_load |-> pref_vld_q);

  // R9
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R8
  oe_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (state_q == ST_DATA));
endmodule

// File: tb/spi_seq_read_tb.sv
module spi_seq_read_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sck = 1'b0;
  logic        si = 1'b0;
  logic        start = 1'b0;
  logic        so_o, so_oe_o, mem_req_o;
  logic [11:0] mem_addr_o;
  logic [7:0]  mem_rdata = 8'h00;

  int    n_chk = 0;
  int    n_fail = 0;
  int    req_cnt = 0;
  logic [11:0] req_log [$];
  logic  exp_oe = 1'b0;
  logic  exp_so = 1'b0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  spi_seq_read dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sck_i       (sck),
    .si_i        (si),
    .start_i     (start),
    .so_o        (so_o),
    .so_oe_o     (so_oe_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata)
  );

  function automatic logic [7:0] memf(input logic [11:0] a);
    return (a[7:0] * 8'd7) + ({4'h0, a[11:8]} * 8'd29) + 8'h11;
  endfunction

  always @(posedge clk) begin
    if (mem_req_o) begin
      mem_rdata <= memf(mem_addr_o);
      req_log.push_back(mem_addr_o);
      req_cnt++;
    end
  end

  task automatic check(input bit cond, input string what, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(so_oe_o === exp_oe, "so_oe_o", int'(so_oe_o), int'(exp_oe));
    check(so_o === exp_so, "so_o", int'(so_o), int'(exp_so));
  endtask

  task automatic end_cs();
    cs_ni  = 1'b1;
    exp_oe = 1'b0;
    exp_so = 1'b0;
    tick();
    sck = 1'b0;
    repeat (3) tick();
  endtask

  // abort_at: index of the SCK bit (address bits first) before which CS rises; -1 = none
  task automatic read_cmd(input logic [15:0] a, input int nbytes, input int abort_at);
    int cnt = 0;
    int req0 = req_cnt;
    int log0 = req_log.size();
    cs_ni = 1'b0;
    tick();
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    for (int i = 15; i >= 0; i--) begin
      if (abort_at == cnt) begin end_cs(); return; end
      sck = 1'b0; si = a[i];
      repeat (4) tick();
      sck = 1'b1;
      repeat (4) tick();
      cnt++;
    end
    for (int k = 0; k < nbytes; k++) begin
      logic [11:0] ea = a[11:0] + 12'(k);
      logic [7:0]  e  = memf(ea);
      for (int b = 7; b >= 0; b--) begin
        if (abort_at == cnt) begin end_cs(); return; end
        sck = 1'b0; exp_oe = 1'b1; exp_so = e[b];
        repeat (4) tick();
        sck = 1'b1;
        repeat (4) tick();
        cnt++;
      end
    end
    end_cs();
    // R9: N complete bytes cost N+1 requests
    check(req_cnt - req0 == nbytes + 1, "R9 request count", req_cnt - req0, nbytes + 1);
    // R3: first request uses only address bits 11..0
    if (req_log.size() > log0)
      check(req_log[log0] == a[11:0], "R3 first mem_addr_o", int'(req_log[log0]), int'(a[11:0]));
    else
      check(1'b0, "R3 no request", 0, int'(a[11:0]));
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) tick();
    check(mem_req_o === 1'b0, "R1 mem_req_o in reset", int'(mem_req_o), 0);
    rst_ni = 1'b1;
    repeat (3) tick();
    check(mem_req_o === 1'b0, "R1 mem_req_o after reset", int'(mem_req_o), 0);

    cur_req = "R2/R4";
    read_cmd(16'h0123, 3, -1);

    cur_req = "R3/R5";
    read_cmd(16'hA7FE, 4, -1);

    cur_req = "R6";
    read_cmd(16'h0FFE, 4, -1);
    read_cmd(16'hFFFF, 2, -1);

    cur_req = "R7";
    read_cmd(16'h0200, 4, 16 + 8 * 2 + 3);
    read_cmd(16'h0040, 2, -1);
    read_cmd(16'h0333, 2, 7);
    read_cmd(16'h0555, 1, -1);

    // R10: start while CS high, then SCK activity with no new start
    cur_req = "R10";
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    cs_ni = 1'b0;
    tick();
    for (int i = 0; i < 24; i++) begin
      sck = 1'b0; si = i[0];
      repeat (4) tick();
      sck = 1'b1;
      repeat (4) tick();
    end
    end_cs();
    cur_req = "R8";
    read_cmd(16'h0ABC, 2, -1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule